// File: doc/BRIEF.md
# Warp Issue Scheduler With Operand Readiness

This block chooses, every clock cycle, one warp from the set resident in a streaming multiprocessor and issues that warp's next instruction. It does this by driving the warp's slot number and its lane mask on the issue port. Each of the 24 warp slots holds four things: a valid flag, an operand-ready flag, a memory-wait flag and the tag of the block that owns it. A warp can be chosen only when it is valid, its operands are ready and it is not waiting on memory. The block therefore skips warps stalled on long-latency loads, and other warps hide that latency at no switch cost.

Blocks arrive with a tag and a thread count. A block is split into 32-lane warps, and those warps take the lowest-numbered free slots. When the block completes, its tag is presented on the release input and every slot carrying that tag is freed. Instruction decode and the datapath sit outside this block. They report operand readiness and memory issue/return through per-warp set and clear strobes.

The control core has two states. `SCH_IDLE` means no warp issued in the previous cycle. `SCH_ISSUE` means a warp was issued. The transition taken at each edge is `SCH_ISSUE` when any warp is eligible and `SCH_IDLE` otherwise. Both states can follow each other, or themselves, back to back.

Top module: `warp_sched`

## Requirements
- R1: After reset no slot is valid, `issue_vld` is 0 and `idle` is 1.
- R2: A load of T threads (T from 1 to 768) takes ceil(T/32) slots, picking the lowest-numbered slots that were free before the edge. Each new warp starts operand-ready, not waiting, and tagged with `blk_tag`. A load with T = 0, or with fewer free slots than needed, changes nothing.
- R3: A warp is eligible when it is valid, operand-ready and not waiting. The issue outputs after an edge name a warp that was eligible in the state before that edge.
- R4: If any warp is eligible before an edge, `issue_vld` is 1 after it, with no empty cycle. Otherwise `issue_vld` is 0. `idle` is always the inverse of `issue_vld`.
- R5: The search starts at the slot after the last issued warp and wraps from 23 to 0. After reset the search starts at slot 0.
- R6: `issue_mask` bit n stands for lane n. The mask is all ones, except for the last warp of a block whose T mod 32 = r is not 0, which has only bits r-1..0 set.
- R7: `rdy_set[i]` sets the ready flag of slot i and `rdy_clr[i]` clears it. If both are asserted in the same cycle, set wins.
- R8: `wait_set[i]` marks slot i as waiting on memory and `mem_ret[i]` clears the mark. If both are asserted in the same cycle, set wins.
- R9: `blk_rel` frees, at the edge, every slot that was valid before the edge and carries `rel_tag`. A load in the same cycle uses only slots that were free before the edge.
- R10: Capacity is 24 warps. Three 256-thread blocks fill every slot, and a further load is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_load | input | 1 | Block arrival strobe |
| blk_tag | input | 3 | Tag of arriving block |
| blk_threads | input | 10 | Thread count of arriving block |
| blk_rel | input | 1 | Block completion strobe |
| rel_tag | input | 3 | Tag of completed block |
| rdy_set | input | 24 | Per-slot operand-ready set |
| rdy_clr | input | 24 | Per-slot operand-ready clear |
| wait_set | input | 24 | Per-slot memory-wait set |
| mem_ret | input | 24 | Per-slot memory-return (wait clear) |
| issue_vld | output | 1 | An instruction issues this cycle |
| issue_warp | output | 5 | Slot number of issued warp |
| issue_mask | output | 32 | Active lanes of issued warp |
| idle | output | 1 | No warp issued this cycle |

## Verification
The assertions assume that a released tag names a block that is resident, and that a load never reuses a tag that is still live. Without those assumptions, slots would mix ownership. The stimulus keeps to them by drawing tags only from a list of tags that the bench model shows to be free, and by releasing only tags that the model shows to be live. Strobes for free slots are allowed, because a load overwrites them. Loads are also sent while slots are short, to exercise rejection.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    localparam int WARP_LANES = 32;

    typedef enum logic {
        SCH_IDLE  = 1'b0,
        SCH_ISSUE = 1'b1
    } sched_state_t;

    function automatic logic [WARP_LANES-1:0] lanes_to_mask(input int n);
        logic [WARP_LANES-1:0] m;
        for (int b = 0; b < WARP_LANES; b++) m[b] = (b < n);
        return m;
    endfunction

endpackage

// File: rtl/warp_slot_table.sv
module warp_slot_table
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int TAG_W     = 3,
    parameter int LANES     = WARP_LANES,
    parameter int THR_W     = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              blk_load,
    input  logic [TAG_W-1:0]                  blk_tag,
    input  logic [THR_W-1:0]                  blk_threads,
    input  logic                              blk_rel,
    input  logic [TAG_W-1:0]                  rel_tag,
    input  logic [NUM_WARPS-1:0]              rdy_set,
    input  logic [NUM_WARPS-1:0]              rdy_clr,
    input  logic [NUM_WARPS-1:0]              wait_set,
    input  logic [NUM_WARPS-1:0]              mem_ret,
    output logic [NUM_WARPS-1:0]              elig,
    output logic [NUM_WARPS-1:0][LANES-1:0]   mask_tab
);

    logic [NUM_WARPS-1:0]  valid_q, rdy_q, wait_q;
    logic [TAG_W-1:0]      tag_q [NUM_WARPS];
    logic [NUM_WARPS-1:0]  alloc, rel_hit;
    logic [NUM_WARPS-1:0][LANES-1:0] new_mask;
    int                    free_cnt, need, seen;
    logic                  load_ok;

    always_comb begin
        free_cnt = 0;
        for (int i = 0; i < NUM_WARPS; i++) free_cnt += {31'd0, ~valid_q[i]};
        need    = (int'(blk_threads) + LANES - 1) / LANES;
        load_ok = blk_load && (need != 0) && (need <= free_cnt);
    end

    always_comb begin
        seen = 0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            alloc[i]    = load_ok && !valid_q[i] && (seen < need);
            new_mask[i] = (seen == need - 1)
                        ? lanes_to_mask(int'(blk_threads) - LANES * seen)
                        : lanes_to_mask(LANES);
            if (!valid_q[i]) seen++;
            rel_hit[i]  = blk_rel && valid_q[i] && (tag_q[i] == rel_tag);
        end
    end

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g]  <= 1'b0;
                rdy_q[g]    <= 1'b0;
                wait_q[g]   <= 1'b0;
                tag_q[g]    <= '0;
                mask_tab[g] <= '0;
            end else if (alloc[g]) begin
                valid_q[g]  <= 1'b1;
                rdy_q[g]    <= 1'b1;
                wait_q[g]   <= 1'b0;
                tag_q[g]    <= blk_tag;
                mask_tab[g] <= new_mask[g];
            end else begin
                valid_q[g]  <= valid_q[g] & ~rel_hit[g];
                rdy_q[g]    <= rdy_set[g] | (rdy_q[g] & ~rdy_clr[g]);
                wait_q[g]   <= wait_set[g] | (wait_q[g] & ~mem_ret[g]);
            end
        end
    end

    assign elig = valid_q & rdy_q & ~wait_q;

    // R8
    wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((wait_q & $past(mem_ret & ~wait_set)) == '0));
    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_rel |=> ((valid_q & $past(rel_hit)) == '0));
    // R2
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc & valid_q) == '0);

endmodule

// File: rtl/warp_pick.sv
module warp_pick #(
    parameter int NUM_WARPS = 24,
    parameter int WID_W     = 5
) (
    input  logic [NUM_WARPS-1:0] req,
    input  logic [WID_W-1:0]     last,
    output logic [NUM_WARPS-1:0] gnt,
    output logic [WID_W-1:0]     gnt_idx,
    output logic                 any
);

    int idx;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        idx     = 0;
        for (int k = 0; k < NUM_WARPS; k++) begin
            idx = int'(last) + 1 + k;
            if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
            if (!any && req[idx]) begin
                any      = 1'b1;
                gnt[idx] = 1'b1;
                gnt_idx  = idx[WID_W-1:0];
            end
        end
    end

endmodule

// File: rtl/warp_sched.sv
module warp_sched
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int TAG_W     = 3,
    parameter int LANES     = WARP_LANES,
    localparam int WID_W    = $clog2(NUM_WARPS),
    localparam int THR_W    = $clog2(NUM_WARPS * LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 blk_load,
    input  logic [TAG_W-1:0]     blk_tag,
    input  logic [THR_W-1:0]     blk_threads,
    input  logic                 blk_rel,
    input  logic [TAG_W-1:0]     rel_tag,
    input  logic [NUM_WARPS-1:0] rdy_set,
    input  logic [NUM_WARPS-1:0] rdy_clr,
    input  logic [NUM_WARPS-1:0] wait_set,
    input  logic [NUM_WARPS-1:0] mem_ret,
    output logic                 issue_vld,
    output logic [WID_W-1:0]     issue_warp,
    output logic [LANES-1:0]     issue_mask,
    output logic                 idle
);

    logic [NUM_WARPS-1:0]            elig, gnt;
    logic [NUM_WARPS-1:0][LANES-1:0] mask_tab;
    logic [WID_W-1:0]                last_q, gnt_idx;
    logic                            any;
    sched_state_t                    st_q;

    warp_slot_table #(
        .NUM_WARPS(NUM_WARPS), .TAG_W(TAG_W), .LANES(LANES), .THR_W(THR_W)
    ) u_tab (
        .clk(clk), .rst_n(rst_n),
        .blk_load(blk_load), .blk_tag(blk_tag), .blk_threads(blk_threads),
        .blk_rel(blk_rel), .rel_tag(rel_tag),
        .rdy_set(rdy_set), .rdy_clr(rdy_clr),
        .wait_set(wait_set), .mem_ret(mem_ret),
        .elig(elig), .mask_tab(mask_tab)
    );

    warp_pick #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_pick (
        .req(elig), .last(last_q), .gnt(gnt), .gnt_idx(gnt_idx), .any(any)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SCH_IDLE;
        else        st_q <= any ? SCH_ISSUE : SCH_IDLE;
    end

    // issue payload and rotation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q     <= WID_W'(NUM_WARPS - 1);
            issue_warp <= '0;
            issue_mask <= '0;
        end else if (any) begin
            last_q     <= gnt_idx;
            issue_warp <= gnt_idx;
            issue_mask <= mask_tab[gnt_idx];
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            SCH_IDLE:  begin issue_vld = 1'b0; idle = 1'b1; end
            SCH_ISSUE: begin issue_vld = 1'b1; idle = 1'b0; end
            default:   begin issue_vld = 1'b0; idle = 1'b1; end
        endcase
    end

    // R3
    issue_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> (issue_vld && $past(elig[gnt_idx])));
    // R4
    no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |=> issue_vld);
    // R3
    grant_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~elig) == '0));
    // R6
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> (issue_mask != '0));
    // R4
    idle_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle != issue_vld);

endmodule

// File: tb/sim_warp_sched.sv
`timescale 1ns/1ps
module sim_warp_sched;

    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_load = 1'b0, blk_rel = 1'b0;
    logic [2:0]  blk_tag = '0, rel_tag = '0;
    logic [9:0]  blk_threads = '0;
    logic [N-1:0] rdy_set = '0, rdy_clr = '0, wait_set = '0, mem_ret = '0;
    logic        issue_vld, idle;
    logic [4:0]  issue_warp;
    logic [31:0] issue_mask;

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;
    string phase = "R1";

    bit m_val[N], m_rdy[N], m_wt[N];
    int m_tag[N], m_lanes[N];
    int m_ptr;
    bit e_vld;
    int e_warp;
    logic [31:0] e_mask;

    always #2.5 clk = ~clk;

    warp_sched u0 (
        .clk(clk), .rst_n(rst_n), .blk_load(blk_load), .blk_tag(blk_tag),
        .blk_threads(blk_threads), .blk_rel(blk_rel), .rel_tag(rel_tag),
        .rdy_set(rdy_set), .rdy_clr(rdy_clr), .wait_set(wait_set),
        .mem_ret(mem_ret), .issue_vld(issue_vld), .issue_warp(issue_warp),
        .issue_mask(issue_mask), .idle(idle)
    );

    function automatic bit tag_live(int t);
        for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == t) return 1;
        return 0;
    endfunction

    task automatic model_step();
        bit pre[N];
        int nf, need, j, sel;
        bit found;
        found = 0; sel = 0;
        for (int k = 1; k <= N; k++) begin
            int w;
            w = (m_ptr + k) % N;
            if (!found && m_val[w] && m_rdy[w] && !m_wt[w]) begin found = 1; sel = w; end
        end
        e_vld = found;
        if (found) begin
            e_warp = sel;
            e_mask = (m_lanes[sel] == 32) ? 32'hFFFF_FFFF : ((32'h1 << m_lanes[sel]) - 1);
            m_ptr = sel;
        end
        nf = 0;
        for (int i = 0; i < N; i++) begin pre[i] = m_val[i]; if (!m_val[i]) nf++; end
        for (int i = 0; i < N; i++) begin
            if (rdy_set[i]) m_rdy[i] = 1; else if (rdy_clr[i]) m_rdy[i] = 0;
            if (wait_set[i]) m_wt[i] = 1; else if (mem_ret[i]) m_wt[i] = 0;
            if (blk_rel && pre[i] && m_tag[i] == int'(rel_tag)) m_val[i] = 0;
        end
        need = (int'(blk_threads) + 31) / 32;
        if (blk_load && need != 0 && need <= nf) begin
            j = 0;
            for (int i = 0; i < N; i++) begin
                if (!pre[i] && j < need) begin
                    m_val[i] = 1; m_rdy[i] = 1; m_wt[i] = 0;
                    m_tag[i] = int'(blk_tag);
                    m_lanes[i] = (j == need - 1) ? int'(blk_threads) - 32 * j : 32;
                    j++;
                end
            end
        end
    endtask

    task automatic compare();
        total++;
        if (issue_vld !== e_vld || idle !== !e_vld) begin
            bad++;
            $display("FAIL %s cyc=%0d vld/idle act=%b/%b exp=%b/%b", phase, cycles,
                     issue_vld, idle, e_vld, !e_vld);
        end else if (e_vld && (int'(issue_warp) != e_warp || issue_mask !== e_mask)) begin
            bad++;
            $display("FAIL %s cyc=%0d warp/mask act=%0d/%h exp=%0d/%h", phase, cycles,
                     issue_warp, issue_mask, e_warp, e_mask);
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1 compare();
        @(negedge clk);
        blk_load = 0; blk_rel = 0;
        rdy_set = '0; rdy_clr = '0; wait_set = '0; mem_ret = '0;
    endtask

    task automatic load(int t, int thr);
        blk_load = 1; blk_tag = 3'(t); blk_threads = 10'(thr);
    endtask

    task automatic rel(int t);
        blk_rel = 1; rel_tag = 3'(t);
    endtask

    always @(posedge clk) cycles++;

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_val[i] = 0; m_rdy[i] = 0; m_wt[i] = 0; m_tag[i] = 0; m_lanes[i] = 32;
        end
        m_ptr = N - 1; e_vld = 0; e_warp = 0; e_mask = '0;
        repeat (3) @(negedge clk);
        phase = "R1";
        compare();
        rst_n = 1;
        tick(); tick();

        // R2 R6: 40-thread block -> two warps, second has 8 lanes
        phase = "R2_R6";
        load(0, 40); tick();
        repeat (5) tick();
        load(1, 0); tick();          // zero threads ignored (R2)
        repeat (3) tick();

        // R10: fill capacity then reject one more
        phase = "R10";
        rel(0); tick();
        load(1, 256); tick();
        load(2, 256); tick();
        load(3, 256); tick();
        load(4, 32); tick();         // rejected: no free slot
        phase = "R5";
        repeat (30) tick();

        // R7: ready clear, set-wins conflict
        phase = "R7";
        rdy_clr = 24'hFF_FFFF; tick();
        repeat (2) tick();
        rdy_set = 24'h00_0101; rdy_clr = 24'h00_0100; tick();
        repeat (4) tick();
        rdy_set = 24'hFF_FFFF; tick();

        // R8: memory waits, return, set-wins conflict
        phase = "R8";
        wait_set = 24'h7F_FFFE; tick();
        repeat (3) tick();
        mem_ret = 24'h00_0006; wait_set = 24'h00_0004; tick();
        repeat (4) tick();
        mem_ret = 24'hFF_FFFF; tick();
        repeat (3) tick();

        // R9: release and load in the same cycle
        phase = "R9";
        rel(2); load(5, 100); tick();
        repeat (6) tick();
        rel(1); rel(1); tick();
        load(6, 300); tick();
        repeat (6) tick();

        // R3 R4: random traffic
        phase = "R3_R4";
        for (int c = 0; c < 4000; c++) begin
            rdy_set  = 24'($urandom) & 24'($urandom);
            rdy_clr  = 24'($urandom) & 24'($urandom);
            wait_set = 24'($urandom) & 24'($urandom) & 24'($urandom);
            mem_ret  = 24'($urandom) & 24'($urandom);
            if ($urandom_range(0, 9) == 0) begin
                int t;
                t = $urandom_range(0, 7);
                if (tag_live(t)) rel(t);
            end
            if ($urandom_range(0, 7) == 0) begin
                int t;
                t = $urandom_range(0, 7);
                if (!tag_live(t) && !(blk_rel && int'(rel_tag) == t))
                    load(t, $urandom_range(0, 300));
            end
            tick();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule